// File: doc/BRIEF.md
# Gaussian Frequency Pulse Shaper

This block produces the sampled instantaneous-frequency waveform of a Gaussian-filtered minimum-shift-keying transmitter. It runs from the fast reference clock and carries its own pseudo-random bit source, which moves to a new bit once per symbol. Every reference cycle it presents the current bit, held as a ±1 square wave for a whole symbol, to a low-pass filter with a near-Gaussian response. The result is a signed frequency-deviation word on every cycle.

The Gaussian response is built as three cascaded moving sums, each 88 samples long. Their combined impulse response has the same variance as a Gaussian with a bandwidth-time product of 0.3 at 100 samples per symbol (sigma ≈ 44 samples), and it fits inside a five-symbol window. A constant gain sets the peak-to-peak deviation: a long run of equal bits settles at ±16384, which stands for ±h·bit-rate/2 (±250 kHz for h = 0.5 at 1 Mbit/s). A phase accumulator, which is not part of this block, can take the word directly.

Top module: `gauss_freq_shaper`

## Requirements
- R1: `tx_bit` changes only on the edge that ends a symbol. A symbol lasts exactly 100 cycles, and after reset release the first symbol occupies cycles 0 to 99.
- R2: The bit source is a 15-bit shift register seeded with all ones. `tx_bit` is state bit 14. At each symbol end the state becomes {state[13:0], state[14]^state[13]}, so the first 15 symbols are ones. The state is never zero.
- R3: `tx_bit` = 1 stands for +1 and 0 stands for −1. In cycle m, let A(m) = Σ h[k]·x[m−4−k] for k in 0 to 261. Here x[n] is the ±1 value of `tx_bit` in cycle n (0 before release), and h[k] is the number of ways to write k as a sum of three integers, each in 0 to 87. Then `freq_word` = (A(m)·25210 + 2^19) >>> 20, where >>> is an arithmetic shift and 25210 is 16384·2^20/88³ rounded to the nearest integer.
- R4: Whenever the whole 262-cycle filter window holds equal bits, `freq_word` is exactly +16384 for ones or −16384 for zeros.
- R5: `freq_word` never goes outside −16384 to +16384.
- R6: `freq_valid` is 0 in cycles 0 to 499 after reset release. It is 1 from cycle 500 on, which is the first cycle of symbol 5, and it stays 1 until the next reset.
- R7: `freq_word`/16384 stays within 0.03 of the ideal response. The ideal response is the held ±1 bit stream filtered by a sampled Gaussian with sigma = √(ln 2)·100/(2π·0.3) samples, centred 134.5 cycles later.
- R8: A synchronous reset, applied at any time, sets `freq_word` to 0, `freq_valid` to 0 and the bit source back to its seed. It also empties the filter history.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference clock; one output sample per cycle |
| rst | input | 1 | Synchronous active-high reset |
| tx_bit | output | 1 | Current data bit (1 = +1, 0 = −1) |
| freq_word | output | 16 | Signed frequency deviation, ±16384 = full deviation |
| freq_valid | output | 1 | High once five symbols have filled the filter |

## Verification
The range checks on the moving sums assume that reset has been asserted for at least one edge before operation, because every delay line must start at zero for the running sums to match their windows. The sticky-valid and symbol-boundary checks assume the same. The bench meets this by holding reset for several edges at start-up and again in the middle of the run. It then compares every cycle with a direct convolution built from its own copy of the bit sequence and a tap table it counts itself. It also measures the distance from a floating-point Gaussian once per symbol.

// File: rtl/gauss_shaper_pkg.sv
package gauss_shaper_pkg;

    localparam int SYM_SAMPLES  = 100;   // reference samples per symbol
    localparam int SPAN_SYMBOLS = 5;     // symbols that must fill the filter
    localparam int BOX_LEN      = 88;    // length of each moving sum
    localparam int BOX_STAGES   = 3;     // cascaded moving sums
    localparam int WORD_W       = 16;
    localparam int FULL_CODE    = 16384; // code for full positive deviation
    localparam int SCALE_SHIFT  = 20;
    localparam int PRBS_W       = 15;
    localparam int PRBS_SEED    = 32'h7FFF;

    typedef struct packed {
        logic sym_end;   // last sample of the current symbol
        logic data_bit;  // bit being transmitted
    } sym_slot_t;

    // Largest magnitude after a number of moving-sum stages.
    function automatic longint box_peak(int len, int stages);
        longint p = 1;
        for (int i = 0; i < stages; i++) p = p * len;
        return p;
    endfunction

    // Gain that maps the settled peak onto the full-scale code, rounded.
    function automatic longint scale_gain(int full, int shift, longint peak);
        return ((longint'(full) <<< shift) + peak / 2) / peak;
    endfunction

endpackage

// File: rtl/gs_prbs_source.sv
module gs_prbs_source #(
    parameter int            W    = 15,
    parameter logic [W-1:0]  SEED = '1
) (
    input  logic clk,
    input  logic rst,
    input  logic advance,
    output logic bit_o
);
    logic [W-1:0] state_q;

    always_ff @(posedge clk) begin
        if (rst)
            state_q <= SEED;
        else if (advance)
            state_q <= {state_q[W-2:0], state_q[W-1] ^ state_q[W-2]};
    end

    assign bit_o = state_q[W-1];

    // R2: the maximal-length register must never collapse to zero
    a_r2_state_nonzero: assert property (@(posedge clk) disable iff (rst)
        state_q != '0);

endmodule

// File: rtl/gs_boxcar_stage.sv
module gs_boxcar_stage #(
    parameter int     DW      = 23,
    parameter int     LEN     = 88,
    parameter longint IN_PEAK = 1
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic signed [DW-1:0] din,
    output logic signed [DW-1:0] sum_o
);
    localparam longint OUT_PEAK = IN_PEAK * LEN;

    logic signed [DW-1:0] tap_q [LEN];
    logic signed [DW-1:0] sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            for (int k = 0; k < LEN; k++) tap_q[k] <= '0;
        end else begin
            sum_q    <= sum_q + din - tap_q[LEN-1];
            tap_q[0] <= din;
            for (int k = 1; k < LEN; k++) tap_q[k] <= tap_q[k-1];
        end
    end

    assign sum_o = sum_q;

    // R3: running sum stays within the window bound of its input
    a_r3_stage_range: assert property (@(posedge clk) disable iff (rst)
        (longint'(sum_q) <= OUT_PEAK) && (longint'(sum_q) >= -OUT_PEAK));

    a_r3_input_range: assert property (@(posedge clk) disable iff (rst)
        (longint'(din) <= IN_PEAK) && (longint'(din) >= -IN_PEAK));

endmodule

// File: rtl/gs_output_scaler.sv
module gs_output_scaler #(
    parameter int     DW     = 23,
    parameter int     WORD_W = 16,
    parameter int     FULL   = 16384,
    parameter int     SHIFT  = 20,
    parameter longint PEAK   = 681472
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic signed [DW-1:0]     acc_i,
    output logic signed [WORD_W-1:0] word_o
);
    import gauss_shaper_pkg::*;

    localparam longint GAIN = scale_gain(FULL, SHIFT, PEAK);
    localparam longint HALF = longint'(1) <<< (SHIFT - 1);

    logic signed [WORD_W-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst)
            word_q <= '0;
        else
            word_q <= WORD_W'((longint'(acc_i) * GAIN + HALF) >>> SHIFT);
    end

    assign word_o = word_q;

    // R5: deviation word never exceeds the full-scale code
    a_r5_within_deviation: assert property (@(posedge clk) disable iff (rst)
        (word_q <= FULL) && (word_q >= -FULL));

endmodule

// File: rtl/gauss_freq_shaper.sv
module gauss_freq_shaper
    import gauss_shaper_pkg::*;
#(
    parameter int SAMPLES = SYM_SAMPLES,
    parameter int SPAN    = SPAN_SYMBOLS,
    parameter int LEN     = BOX_LEN,
    parameter int STAGES  = BOX_STAGES,
    parameter int OUT_W   = WORD_W,
    parameter int FULL    = FULL_CODE,
    parameter int SHIFT   = SCALE_SHIFT,
    parameter int LFSR_W  = PRBS_W,
    parameter int SEED    = PRBS_SEED
) (
    input  logic                    clk,
    input  logic                    rst,
    output logic                    tx_bit,
    output logic signed [OUT_W-1:0] freq_word,
    output logic                    freq_valid
);
    localparam int     PH_W   = $clog2(SAMPLES);
    localparam int     FILL   = SPAN * SAMPLES;
    localparam int     FILL_W = $clog2(FILL + 1);
    localparam int     ACC_W  = 2 + STAGES * $clog2(LEN);
    localparam longint PEAK   = box_peak(LEN, STAGES);

    logic [PH_W-1:0]   phase_q;
    logic [FILL_W-1:0] fill_q;
    sym_slot_t         slot;

    assign slot.sym_end = (phase_q == PH_W'(SAMPLES - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
            fill_q  <= '0;
        end else begin
            phase_q <= slot.sym_end ? '0 : phase_q + 1'b1;
            if (fill_q != FILL_W'(FILL)) fill_q <= fill_q + 1'b1;
        end
    end

    gs_prbs_source #(
        .W    (LFSR_W),
        .SEED (LFSR_W'(SEED))
    ) u_prbs (
        .clk     (clk),
        .rst     (rst),
        .advance (slot.sym_end),
        .bit_o   (slot.data_bit)
    );

    logic signed [ACC_W-1:0] chain [STAGES+1];

    assign chain[0] = slot.data_bit ? {{(ACC_W-1){1'b0}}, 1'b1} : '1;

    for (genvar g = 0; g < STAGES; g++) begin : g_box
        gs_boxcar_stage #(
            .DW      (ACC_W),
            .LEN     (LEN),
            .IN_PEAK (box_peak(LEN, g))
        ) u_box (
            .clk   (clk),
            .rst   (rst),
            .din   (chain[g]),
            .sum_o (chain[g+1])
        );
    end

    gs_output_scaler #(
        .DW     (ACC_W),
        .WORD_W (OUT_W),
        .FULL   (FULL),
        .SHIFT  (SHIFT),
        .PEAK   (PEAK)
    ) u_scale (
        .clk    (clk),
        .rst    (rst),
        .acc_i  (chain[STAGES]),
        .word_o (freq_word)
    );

    assign tx_bit     = slot.data_bit;
    assign freq_valid = (fill_q == FILL_W'(FILL));

    // R1: the bit may only change on the edge that closes a symbol
    a_r1_bit_held: assert property (@(posedge clk) disable iff (rst)
        !slot.sym_end |=> $stable(tx_bit));

    // R6: once valid, stays valid until reset
    a_r6_valid_sticky: assert property (@(posedge clk) disable iff (rst)
        freq_valid |=> freq_valid);

    // R6: valid rises exactly on a symbol boundary
    a_r6_valid_on_boundary: assert property (@(posedge clk) disable iff (rst)
        $rose(freq_valid) |-> (phase_q == PH_W'(FILL % SAMPLES)));

endmodule

// File: tb/gauss_freq_shaper_tb_top.sv
module gauss_freq_shaper_tb_top;

    localparam int NSYM  = 80;
    localparam int SPS   = 100;
    localparam int NTAP  = 262;
    localparam int LAT   = 4;
    localparam longint PK = 681472;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic tx_bit;
    logic signed [15:0] freq_word;
    logic freq_valid;

    int n_cmp = 0;
    int n_bad = 0;
    int h [NTAP];
    bit bits [NSYM];

    always #4 clk = ~clk;

    gauss_freq_shaper dut_i (
        .clk        (clk),
        .rst        (rst),
        .tx_bit     (tx_bit),
        .freq_word  (freq_word),
        .freq_valid (freq_valid)
    );

    task automatic check(string req, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d @%0t", req, act, exp, $time);
        end
    endtask

    function automatic int xs(int n);
        if (n < 0) return 0;
        return bits[n / SPS] ? 1 : -1;
    endfunction

    function automatic longint raw_at(int m);
        longint s = 0;
        for (int k = 0; k < NTAP; k++) s += longint'(h[k]) * xs(m - LAT - k);
        return s;
    endfunction

    function automatic longint scale(longint a);
        return (a * 25210 + 524288) >>> 20;
    endfunction

    function automatic real erf_a(real x);
        real t, y, ax;
        ax = (x < 0.0) ? -x : x;
        t  = 1.0 / (1.0 + 0.3275911 * ax);
        y  = 1.0 - (((((1.061405429 * t - 1.453152027) * t) + 1.421413741) * t
             - 0.284496736) * t + 0.254829592) * t * $exp(-ax * ax);
        return (x < 0.0) ? -y : y;
    endfunction

    function automatic real phi(real z);
        return 0.5 * (1.0 + erf_a(z / $sqrt(2.0)));
    endfunction

    function automatic real gauss_ideal(int m);
        real sg, acc, w;
        sg  = $sqrt($ln(2.0)) * 100.0 / (2.0 * 3.14159265358979 * 0.3);
        acc = 0.0;
        for (int k = 0; k <= 400; k++) begin
            w = phi((k + 0.5 - 130.5) / sg) - phi((k - 0.5 - 130.5) / sg);
            acc += w * xs(m - LAT - k);
        end
        return acc;
    endfunction

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        check("R8 word in reset", freq_word, 0);
        check("R8 valid in reset", freq_valid, 0);
        check("R8 seed bit in reset", tx_bit, 1);
        @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic run_cycles(int ncyc);
        longint raw, ex;
        real    gi, diff;
        for (int m = 1; m <= ncyc; m++) begin
            @(posedge clk);
            #1;
            check("R2 bit sequence", tx_bit, bits[m / SPS]);
            check("R6 valid timing", freq_valid, (m >= 500) ? 1 : 0);
            if (m == 1450) check("R2 first fifteen ones", tx_bit, 1);
            if (m == 1000) check("R4 settled positive run", freq_word, 16384);
            if (m >= 500) begin
                raw = raw_at(m);
                ex  = scale(raw);
                check("R3 filtered word", freq_word, ex);
                if (raw == PK)  check("R4 full positive", freq_word, 16384);
                if (raw == -PK) check("R4 full negative", freq_word, -16384);
                if (freq_word > 16384 || freq_word < -16384)
                    check("R5 range", freq_word, ex);
            end
            if (m >= 600 && (m % SPS) == 50) begin
                gi   = gauss_ideal(m);
                diff = real'(freq_word) / 16384.0 - gi;
                n_cmp++;
                if (diff > 0.03 || diff < -0.03) begin
                    n_bad++;
                    $display("FAIL R7 gaussian shape actual=%0d expected=%0d",
                             freq_word, $rtoi(gi * 16384.0));
                end
            end
        end
    endtask

    initial begin
        logic [14:0] s;
        for (int k = 0; k < NTAP; k++) h[k] = 0;
        for (int a = 0; a < 88; a++)
            for (int b = 0; b < 88; b++)
                for (int c = 0; c < 88; c++)
                    h[a + b + c]++;
        s = 15'h7FFF;
        for (int i = 0; i < NSYM; i++) begin
            bits[i] = s[14];
            s = {s[13:0], s[14] ^ s[13]};
        end

        do_reset();
        run_cycles(NSYM * SPS - 1);
        do_reset();
        run_cycles(800);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 200000, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule